// File: doc/BRIEF.md
# Address-Region Chip-Select Decoder

This block watches a 16-bit address bus together with a bus-cycle strobe and a read/write line, and drives one chip-select line per memory or I/O region. The map is set at elaboration time through parameters. Every region is described as the OR of up to two mask/compare terms, so a region whose size is not a power of two, or whose base is not a multiple of its size, still decodes exactly with no aliasing. By default every address bit takes part in the decode.

Alongside the chip selects the block produces a read enable and a write enable that qualify the selected device, and a bus-error flag for a strobed access that falls in no region. All outputs leave flip-flops one clock after the inputs are sampled, so the devices downstream never see decoder glitches. The block checks at elaboration time that no two regions overlap, and stops the build if they do.

The default map has eight regions. Index 0 is a 4 KB RAM. Index 1 is a 12 KB area built from two terms. Index 2 is a 1 KB RAM. Indices 3 and 4 are the input and output ports. Index 5 is a single-address I/O device. Index 6 is a 24 KB misaligned area built from two terms. Index 7 is a 16 KB ROM.

Top module: `cs_decoder`

## Requirements
- R1: With the strobe high, an address from 0x0000 to 0x0FFF asserts cs_o bit 0 only.
- R2: With the strobe high, an address from 0x1000 to 0x3FFF asserts cs_o bit 1 only. This region is the union of the patterns 0001xxxx... and 001xxxxx...
- R3: With the strobe high, an address from 0x4000 to 0x43FF asserts cs_o bit 2 only.
- R4: With the strobe high, address 0x5000 asserts cs_o bit 3 and address 0x5001 asserts cs_o bit 4. The neighbouring addresses select neither bit.
- R5: With the strobe high, cs_o bit 5 is asserted only by address 0x5500 exactly.
- R6: With the strobe high, an address from 0x6000 to 0xBFFF asserts cs_o bit 6 only. This region is the union of the patterns 011xxxxx... and 10xxxxxx...
- R7: With the strobe high, an address from 0xC000 to 0xFFFF asserts cs_o bit 7 only.
- R8: When the strobe is low, cs_o, rd_en_o, wr_en_o and bus_err_o are all 0, whatever the address and read/write values are.
- R9: When the strobe is high on a mapped address, rw_i=1 gives rd_en_o=1 and wr_en_o=0, and rw_i=0 gives wr_en_o=1 and rd_en_o=0. The two enables are never high together.
- R10: When the strobe is high on an unmapped address (for example 0x4400 to 0x4FFF, 0x5002 to 0x54FF, or 0x5501 to 0x5FFF), cs_o is 0, both enables are 0 and bus_err_o is 1.
- R11: At most one cs_o bit is high in any cycle, and bus_err_o is never high together with a chip select.
- R12: All outputs are 0 during reset. An input sampled at one rising clock edge shows on the outputs after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_i | input | 16 | Bus address |
| strobe_i | input | 1 | High while a bus cycle is valid |
| rw_i | input | 1 | 1 = read, 0 = write; used only while the strobe is high |
| cs_o | output | 8 | Registered chip select, one bit per region |
| rd_en_o | output | 1 | Registered read enable for the selected device |
| wr_en_o | output | 1 | Registered write enable for the selected device |
| bus_err_o | output | 1 | Registered flag for a strobed access to an unmapped address |

## Verification
The assertions check on every cycle that the chip selects are one-hot or idle, and that a chip select and the error flag are never high together. They also check that the two enables exclude each other, that a low strobe gives quiet outputs one cycle later, and that the read and write enables track whether a region was hit. Only the bench scenarios can show that each region answers to exactly its own address range. They walk the first and last address of every region, the edges of each two-term join, the gaps that must raise the error flag, and the one-cycle alignment of the outputs to the sampled inputs.

// File: rtl/cs_decoder_pkg.sv
package cs_decoder_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic err;
  } cs_ctrl_t;

  // Two mask/compare terms can hit the same address only if they agree
  // on every bit that both of them compare.
  function automatic bit terms_collide(input logic [15:0] mask_a,
                                       input logic [15:0] cmp_a,
                                       input logic [15:0] mask_b,
                                       input logic [15:0] cmp_b);
    return (((cmp_a ^ cmp_b) & mask_a & mask_b) == 16'h0000);
  endfunction

endpackage

// File: rtl/cs_term_match.sv
module cs_term_match #(
  parameter int          AW    = 16,
  parameter logic [AW-1:0] MASK  = '0,
  parameter logic [AW-1:0] CMP   = '0,
  parameter bit          USED  = 1'b0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  generate
    if (USED) begin : g_used
      assign hit = ((addr & MASK) == (CMP & MASK));
    end else begin : g_unused
      assign hit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cs_region.sv
module cs_region #(
  parameter int                 AW       = 16,
  parameter int                 NTERM    = 2,
  parameter logic [NTERM*AW-1:0] MASKS   = '0,
  parameter logic [NTERM*AW-1:0] CMPS    = '0,
  parameter logic [NTERM-1:0]    USED    = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [NTERM-1:0] term_hit;

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    cs_term_match #(
      .AW   (AW),
      .MASK (MASKS[t*AW +: AW]),
      .CMP  (CMPS[t*AW +: AW]),
      .USED (USED[t])
    ) u_term (
      .addr (addr),
      .hit  (term_hit[t])
    );
  end

  assign hit = |term_hit;

endmodule

// File: rtl/cs_bus_qual.sv
module cs_bus_qual
  import cs_decoder_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0] region_hit,
  input  logic            strobe,
  input  logic            rw,
  output logic [NREG-1:0] cs_d,
  output cs_ctrl_t        ctrl_d
);

  logic any_hit;

  always_comb begin
    any_hit    = |region_hit;
    cs_d       = strobe ? region_hit : '0;
    ctrl_d.rd  = strobe &  rw & any_hit;
    ctrl_d.wr  = strobe & ~rw & any_hit;
    ctrl_d.err = strobe & ~any_hit;
  end

endmodule

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cs_out_reg.sv
module cs_out_reg
  import cs_decoder_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NREG-1:0] cs_d,
  input  cs_ctrl_t        ctrl_d,
  output logic [NREG-1:0] cs_q,
  output cs_ctrl_t        ctrl_q
);

  logic [NREG-1:0] cs_nxt;
  cs_ctrl_t        ctrl_nxt;

  always_comb begin
    cs_nxt   = cs_q;
    ctrl_nxt = ctrl_q;
    if (en) begin
      cs_nxt   = cs_d;
      ctrl_nxt = ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '0;
      ctrl_q <= '0;
    end else begin
      cs_q   <= cs_nxt;
      ctrl_q <= ctrl_nxt;
    end
  end

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_decoder_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NREG  = 8,
  parameter int NTERM = 2,
  // term k = region*NTERM + t occupies bits [k*AW +: AW]
  parameter logic [NREG*NTERM*AW-1:0] TERM_MASK = {
    16'h0000, 16'hC000,   // region 7: ROM
    16'hC000, 16'hE000,   // region 6: 0x8000-0xBFFF | 0x6000-0x7FFF
    16'h0000, 16'hFFFF,   // region 5: single I/O
    16'h0000, 16'hFFFF,   // region 4: output port
    16'h0000, 16'hFFFF,   // region 3: input port
    16'h0000, 16'hFC00,   // region 2: 1 KB RAM
    16'hE000, 16'hF000,   // region 1: 0x2000-0x3FFF | 0x1000-0x1FFF
    16'h0000, 16'hF000    // region 0: 4 KB RAM
  },
  parameter logic [NREG*NTERM*AW-1:0] TERM_CMP = {
    16'h0000, 16'hC000,
    16'h8000, 16'h6000,
    16'h0000, 16'h5500,
    16'h0000, 16'h5001,
    16'h0000, 16'h5000,
    16'h0000, 16'h4000,
    16'h2000, 16'h1000,
    16'h0000, 16'h0000
  },
  parameter logic [NREG*NTERM-1:0] TERM_USED = 16'b01_11_01_01_01_01_11_01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            strobe_i,
  input  logic            rw_i,
  output logic [NREG-1:0] cs_o,
  output logic            rd_en_o,
  output logic            wr_en_o,
  output logic            bus_err_o
);

  localparam int NTOT = NREG * NTERM;

  // Count pairs of live terms from different regions that can collide.
  function automatic int count_collisions();
    int n;
    n = 0;
    for (int a = 0; a < NTOT; a++) begin
      for (int b = a + 1; b < NTOT; b++) begin
        if (TERM_USED[a] && TERM_USED[b] && ((a / NTERM) != (b / NTERM))) begin
          if (terms_collide(TERM_MASK[a*AW +: 16], TERM_CMP[a*AW +: 16],
                            TERM_MASK[b*AW +: 16], TERM_CMP[b*AW +: 16])) begin
            n++;
          end
        end
      end
    end
    return n;
  endfunction

  localparam int COLLISIONS = count_collisions();

  generate
    if (AW != 16) begin : g_bad_width
      $error("cs_decoder: address width must be 16");
    end
    if (COLLISIONS != 0) begin : g_bad_map
      $error("cs_decoder: region map has overlapping regions");
    end
  endgenerate

  logic            rst_n_sync;
  logic [NREG-1:0] region_hit;
  logic [NREG-1:0] cs_d;
  logic [NREG-1:0] cs_q;
  cs_ctrl_t        ctrl_d;
  cs_ctrl_t        ctrl_q;

  cs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_region
    cs_region #(
      .AW    (AW),
      .NTERM (NTERM),
      .MASKS (TERM_MASK[r*NTERM*AW +: NTERM*AW]),
      .CMPS  (TERM_CMP[r*NTERM*AW +: NTERM*AW]),
      .USED  (TERM_USED[r*NTERM +: NTERM])
    ) u_region (
      .addr (addr_i),
      .hit  (region_hit[r])
    );
  end

  cs_bus_qual #(.NREG(NREG)) u_qual (
    .region_hit (region_hit),
    .strobe     (strobe_i),
    .rw         (rw_i),
    .cs_d       (cs_d),
    .ctrl_d     (ctrl_d)
  );

  cs_out_reg #(.NREG(NREG)) u_out (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .en     (1'b1),
    .cs_d   (cs_d),
    .ctrl_d (ctrl_d),
    .cs_q   (cs_q),
    .ctrl_q (ctrl_q)
  );

  assign cs_o      = cs_q;
  assign rd_en_o   = ctrl_q.rd;
  assign wr_en_o   = ctrl_q.wr;
  assign bus_err_o = ctrl_q.err;

endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk #(
  parameter int AW   = 16,
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr_i,
  input logic            strobe_i,
  input logic            rw_i,
  input logic [NREG-1:0] cs_o,
  input logic            rd_en_o,
  input logic            wr_en_o,
  input logic            bus_err_o
);

  logic unused_addr;
  assign unused_addr = ^addr_i;

  // R11
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));

  // R11
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> (cs_o == '0));

  // R9
  enables_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_o && wr_en_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ((cs_o == '0) && !rd_en_o && !wr_en_o && !bus_err_o));

  // R9
  read_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && rw_i) |=> (!wr_en_o && (rd_en_o == (cs_o != '0))));

  // R9
  write_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !rw_i) |=> (!rd_en_o && (wr_en_o == (cs_o != '0))));

endmodule

bind cs_decoder cs_decoder_chk #(.AW(AW), .NREG(NREG)) u_chk (.*);

// File: tb/tb_cs_decoder.sv
`timescale 1ns/1ps
module tb_cs_decoder;

  logic        clk;
  logic        rst_n;
  logic [15:0] addr_i;
  logic        strobe_i;
  logic        rw_i;
  logic [7:0]  cs_o;
  logic        rd_en_o;
  logic        wr_en_o;
  logic        bus_err_o;

  int errors = 0;
  int checks = 0;

  cs_decoder dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .strobe_i  (strobe_i),
    .rw_i      (rw_i),
    .cs_o      (cs_o),
    .rd_en_o   (rd_en_o),
    .wr_en_o   (wr_en_o),
    .bus_err_o (bus_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected region select from the address ranges in the requirements
  function automatic logic [7:0] ref_cs(input logic [15:0] a);
    if (a <= 16'h0FFF)                         return 8'h01;
    if (a >= 16'h1000 && a <= 16'h3FFF)        return 8'h02;
    if (a >= 16'h4000 && a <= 16'h43FF)        return 8'h04;
    if (a == 16'h5000)                         return 8'h08;
    if (a == 16'h5001)                         return 8'h10;
    if (a == 16'h5500)                         return 8'h20;
    if (a >= 16'h6000 && a <= 16'hBFFF)        return 8'h40;
    if (a >= 16'hC000)                         return 8'h80;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got cs=%02h rd=%0b wr=%0b err=%0b, expected cs=%02h rd=%0b wr=%0b err=%0b",
               req, act[10:3], act[2], act[1], act[0], exp[10:3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [10:0] outs();
    return {cs_o, rd_en_o, wr_en_o, bus_err_o};
  endfunction

  function automatic logic [10:0] expect_for(input logic [15:0] a, input logic s, input logic rw);
    logic [7:0] c;
    c = s ? ref_cs(a) : 8'h00;
    return {c, s & rw & (c != 0), s & ~rw & (c != 0), s & (ref_cs(a) == 0)};
  endfunction

  // drive at the falling edge, sample just after the next rising edge
  task automatic access(input string req, input logic [15:0] a, input logic s, input logic rw);
    @(negedge clk);
    addr_i = a; strobe_i = s; rw_i = rw;
    @(posedge clk);
    #1;
    check(req, outs(), expect_for(a, s, rw));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr_i = 16'h5500; strobe_i = 1'b1; rw_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset", outs(), 11'h0);
    @(negedge clk);
    rst_n = 1'b1; strobe_i = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R12 after reset", outs(), 11'h0);
  endtask

  task automatic t_regions();
    access("R1 ram4k low",    16'h0000, 1, 1);
    access("R1 ram4k high",   16'h0FFF, 1, 0);
    access("R2 area low",     16'h1000, 1, 1);
    access("R2 term join lo", 16'h1FFF, 1, 1);
    access("R2 term join hi", 16'h2000, 1, 0);
    access("R2 area high",    16'h3FFF, 1, 1);
    access("R3 ram1k low",    16'h4000, 1, 1);
    access("R3 ram1k high",   16'h43FF, 1, 0);
    access("R4 input port",   16'h5000, 1, 1);
    access("R4 output port",  16'h5001, 1, 0);
    access("R5 io exact",     16'h5500, 1, 1);
    access("R5 io minus one", 16'h54FF, 1, 1);
    access("R6 area low",     16'h6000, 1, 1);
    access("R6 term join lo", 16'h7FFF, 1, 0);
    access("R6 term join hi", 16'h8000, 1, 1);
    access("R6 area high",    16'hBFFF, 1, 0);
    access("R7 rom low",      16'hC000, 1, 1);
    access("R7 rom high",     16'hFFFF, 1, 1);
  endtask

  task automatic t_idle();
    access("R8 idle ram",  16'h0100, 0, 1);
    access("R8 idle io",   16'h5500, 0, 0);
    access("R8 idle gap",  16'h4400, 0, 1);
    access("R8 idle rom",  16'hFFFF, 0, 0);
  endtask

  task automatic t_rw();
    access("R9 read rom",   16'hD000, 1, 1);
    access("R9 write rom",  16'hD000, 1, 0);
    access("R9 write port", 16'h5001, 1, 0);
    access("R9 read port",  16'h5000, 1, 1);
  endtask

  task automatic t_unmapped();
    access("R10 gap 4400", 16'h4400, 1, 1);
    access("R10 gap 4FFF", 16'h4FFF, 1, 0);
    access("R10 gap 5002", 16'h5002, 1, 1);
    access("R10 gap 5501", 16'h5501, 1, 0);
    access("R10 gap 5FFF", 16'h5FFF, 1, 1);
  endtask

  task automatic t_walk();
    // R11: one select at most, swept over the whole space in coarse steps
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] a;
      a = 16'(i * 16 + (i % 16));
      access("R11 sweep", a, 1, i[0]);
      checks++;
      if ($countones(cs_o) > 1 || (bus_err_o && cs_o != 0)) begin
        errors++;
        $display("FAIL R11: addr %04h cs=%02h err=%0b, expected at most one select", a, cs_o, bus_err_o);
      end
    end
  endtask

  task automatic t_latency();
    access("R12 setup", 16'h0010, 1, 1);
    @(negedge clk);
    addr_i = 16'hC123; strobe_i = 1'b1; rw_i = 1'b0;
    #2;
    check("R12 hold before edge", outs(), expect_for(16'h0010, 1, 1));
    @(posedge clk);
    #1;
    check("R12 update after edge", outs(), expect_for(16'hC123, 1, 0));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_regions();
    t_idle();
    t_rw();
    t_unmapped();
    t_latency();
    t_walk();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule